// File: doc/BRIEF.md
# Flag-generating integer ALU

A single-cycle 32-bit integer arithmetic and logic unit for a two-operand register machine. Each operation reads a destination operand and a source operand, and a shift instruction also reads an immediate count. The unit offers eight operations: add, subtract, bitwise AND, OR and XOR, compare, test, and logical shift left. It produces the result and a writeback enable in the same cycle. It also produces six status flags: carry, parity, auxiliary carry, zero, sign and overflow.

The flags follow the classic two-operand CISC conventions. Parity looks only at the low byte of the result. Auxiliary carry reports the carry or borrow at bit 3. Compare and test change the flags but never request a register write. A flag register captures the new flags on every clock edge where an operation is presented. A one-cycle strobe then announces that the register holds fresh contents.

Top module: `flag_alu`

## Requirements
- R1: Add (opSel 0) gives dstIn+srcIn and subtract (opSel 1) gives dstIn−srcIn, both modulo 2^32. In the same cycle, wrEn is high while opValid is high.
- R2: AND (opSel 2), OR (opSel 3) and XOR (opSel 4) give the bitwise result of dstIn and srcIn, with wrEn high while opValid is high.
- R3: Compare (opSel 5) computes dstIn−srcIn and test (opSel 6) computes dstIn AND srcIn on result, and both only set flags: wrEn stays low.
- R4: Shift left (opSel 7) gives dstIn shifted left by shAmtIn[4:0], zero filled, with wrEn high. The upper count bits are ignored.
- R5: Carry (flag bit 0) is the unsigned carry-out of add and the borrow of subtract or compare. It is 0 after AND, OR, XOR and test.
- R6: Parity (flag bit 1) is 1 when result[7:0] holds an even number of ones. Bits 31:8 do not affect it.
- R7: Auxiliary carry (flag bit 2) is the carry out of bit 3 on add, or the borrow into bit 3 on subtract or compare. It is 0 after the logic operations and after a shift with a nonzero count.
- R8: Zero (flag bit 3) is 1 when all 32 result bits are 0. Sign (flag bit 4) equals result bit 31.
- R9: Overflow (flag bit 5) flags signed two's-complement overflow on add, subtract and compare. It is 0 after AND, OR, XOR and test.
- R10: For a shift with a nonzero masked count, carry is the last bit shifted out. For a masked count of 1, overflow is result[31] XOR carry. For larger counts, overflow keeps its previous value.
- R11: For a shift whose masked count is 0, result equals dstIn and every flag keeps its previous value.
- R12: flagsQ loads curFlags on a rising clk edge with opValid high and otherwise holds. flagsValid is high in the cycle after each such edge. Both are 0 after reset (rstN low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | An operation is presented this cycle |
| opSel | input | 3 | Operation: 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 compare, 6 test, 7 shift left |
| dstIn | input | 32 | Destination operand |
| srcIn | input | 32 | Source operand |
| shAmtIn | input | 8 | Shift count; only bits 4:0 are used |
| result | output | 32 | Combinational result |
| wrEn | output | 1 | Result should be written to the destination |
| curFlags | output | 6 | Combinational flags {OF,SF,ZF,AF,PF,CF}, bit 0 = CF |
| flagsQ | output | 6 | Registered flags, same layout |
| flagsValid | output | 1 | flagsQ was updated on the last edge |

## Verification
Several flag rules can act on the same operation. A signed overflow can coincide with a nibble carry. A shift by one can set carry and overflow together. A shift by a larger count keeps the overflow value left by the operation before it. The vector table orders shifts so that each one inherits a known overflow value, and it includes a shift whose upper count bits are set so that the masked count is 1. Each vector is judged on the combinational result and writeback enable. It is then judged on the registered flags and the strobe, sampled one clock later.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_CMP  = 3'd5,
    OP_TEST = 3'd6,
    OP_SHL  = 3'd7
  } aluOp_e;

  typedef enum logic [1:0] {
    LOG_AND = 2'd0,
    LOG_OR  = 2'd1,
    LOG_XOR = 2'd2
  } logicSel_e;

  // Flag word, bit 0 = carry .. bit 5 = overflow
  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } flags_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic      doSub;
    logic      doLogic;
    logicSel_e logicSel;
    logic      doShift;
    logic      writeBack;
    logic      loadFlags;
    logic      keepFlags;
  } aluCtrl_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
#(
  parameter int SHW  = 5,
  parameter int CNTW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            opValid,
  input  logic [2:0]      opSel,
  input  logic [CNTW-1:0] shAmtIn,
  output aluCtrl_t        ctrl,
  output logic [SHW-1:0]  shCnt,
  output logic            flagsValid
);

  aluOp_e op;

  assign op    = aluOp_e'(opSel);
  assign shCnt = shAmtIn[SHW-1:0];

  always_comb begin
    ctrl           = '0;
    ctrl.logicSel  = LOG_AND;
    ctrl.loadFlags = opValid;
    unique case (op)
      OP_ADD:  ctrl.writeBack = opValid;
      OP_SUB:  begin ctrl.doSub = 1'b1; ctrl.writeBack = opValid; end
      OP_AND:  begin ctrl.doLogic = 1'b1; ctrl.writeBack = opValid; end
      OP_OR:   begin ctrl.doLogic = 1'b1; ctrl.logicSel = LOG_OR;  ctrl.writeBack = opValid; end
      OP_XOR:  begin ctrl.doLogic = 1'b1; ctrl.logicSel = LOG_XOR; ctrl.writeBack = opValid; end
      OP_CMP:  ctrl.doSub = 1'b1;
      OP_TEST: ctrl.doLogic = 1'b1;
      OP_SHL:  begin
        ctrl.doShift   = 1'b1;
        ctrl.writeBack = opValid;
        ctrl.keepFlags = (shCnt == '0);
      end
      default: ctrl.writeBack = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagsValid <= 1'b0;
    else       flagsValid <= opValid;
  end

  // R3: flag-only operations never request a write
  p_no_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_CMP || opSel == OP_TEST) |-> !ctrl.writeBack);

  // R12: strobe follows each accepted operation by one cycle
  p_strobe_set_r12: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> flagsValid);
  p_strobe_clr_r12: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !flagsValid);

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int SHW   = $clog2(WIDTH),
  parameter int PARW  = 8,
  parameter int NIBW  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  aluCtrl_t         ctrl,
  input  logic [WIDTH-1:0] dstIn,
  input  logic [WIDTH-1:0] srcIn,
  input  logic [SHW-1:0]   shCnt,
  output logic [WIDTH-1:0] result,
  output flags_t           curFlags,
  output flags_t           flagsQ
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] addB;
  logic [WIDTH:0]   sumExt;
  logic [NIBW:0]    nibSum;
  logic [WIDTH-1:0] logicRes;
  logic [WIDTH:0]   shiftExt;
  logic             addCarry;
  logic             addAux;
  logic             addOvf;

  // Adder shared by add, subtract and compare
  always_comb begin
    addB     = ctrl.doSub ? ~srcIn : srcIn;
    sumExt   = {1'b0, dstIn} + {1'b0, addB} + {{WIDTH{1'b0}}, ctrl.doSub};
    nibSum   = {1'b0, dstIn[NIBW-1:0]} + {1'b0, addB[NIBW-1:0]}
             + {{NIBW{1'b0}}, ctrl.doSub};
    addCarry = sumExt[WIDTH] ^ ctrl.doSub;
    addAux   = nibSum[NIBW] ^ ctrl.doSub;
    addOvf   = (dstIn[MSB] == addB[MSB]) && (sumExt[MSB] != dstIn[MSB]);
  end

  always_comb begin
    unique case (ctrl.logicSel)
      LOG_OR:  logicRes = dstIn | srcIn;
      LOG_XOR: logicRes = dstIn ^ srcIn;
      default: logicRes = dstIn & srcIn;
    endcase
  end

  // Extra top bit catches the last bit shifted out
  assign shiftExt = {1'b0, dstIn} << shCnt;

  always_comb begin
    curFlags = flagsQ;
    if (ctrl.doShift) begin
      result = shiftExt[MSB:0];
      if (!ctrl.keepFlags) begin
        curFlags.cf = shiftExt[WIDTH];
        curFlags.af = 1'b0;
        if (shCnt == SHW'(1)) curFlags.of = result[MSB] ^ shiftExt[WIDTH];
      end
    end else if (ctrl.doLogic) begin
      result      = logicRes;
      curFlags.cf = 1'b0;
      curFlags.of = 1'b0;
      curFlags.af = 1'b0;
    end else begin
      result      = sumExt[MSB:0];
      curFlags.cf = addCarry;
      curFlags.of = addOvf;
      curFlags.af = addAux;
    end
    if (!(ctrl.doShift && ctrl.keepFlags)) begin
      curFlags.zf = (result == '0);
      curFlags.sf = result[MSB];
      curFlags.pf = ~^result[PARW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               flagsQ <= '0;
    else if (ctrl.loadFlags) flagsQ <= curFlags;
  end

  // R12: register holds when nothing is presented
  p_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.loadFlags |=> $stable(flagsQ));

  // R11: zero-count shift leaves the flags alone
  p_shift_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadFlags && ctrl.keepFlags) |=> $stable(flagsQ));

  // R8: registered zero and sign match the result that was loaded
  p_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadFlags && !ctrl.keepFlags) |=> (flagsQ.zf == ($past(result) == '0)));
  p_sign_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadFlags && !ctrl.keepFlags) |=> (flagsQ.sf == $past(result[MSB])));

  // R5, R9: logic operations clear carry and overflow
  p_logic_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadFlags && ctrl.doLogic) |=> (!flagsQ.cf && !flagsQ.of && !flagsQ.af));

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int CNTW  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [2:0]       opSel,
  input  logic [WIDTH-1:0] dstIn,
  input  logic [WIDTH-1:0] srcIn,
  input  logic [CNTW-1:0]  shAmtIn,
  output logic [WIDTH-1:0] result,
  output logic             wrEn,
  output logic [5:0]       curFlags,
  output logic [5:0]       flagsQ,
  output logic             flagsValid
);

  localparam int SHW = $clog2(WIDTH);

  aluCtrl_t       ctrl;
  logic [SHW-1:0] shCnt;
  flags_t         flagsNow;
  flags_t         flagsReg;

  alu_ctrl #(.SHW(SHW), .CNTW(CNTW)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .opValid    (opValid),
    .opSel      (opSel),
    .shAmtIn    (shAmtIn),
    .ctrl       (ctrl),
    .shCnt      (shCnt),
    .flagsValid (flagsValid)
  );

  alu_datapath #(.WIDTH(WIDTH), .SHW(SHW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .dstIn    (dstIn),
    .srcIn    (srcIn),
    .shCnt    (shCnt),
    .result   (result),
    .curFlags (flagsNow),
    .flagsQ   (flagsReg)
  );

  assign wrEn     = ctrl.writeBack;
  assign curFlags = flagsNow;
  assign flagsQ   = flagsReg;

endmodule

// File: tb/sim_flag_alu.sv
`timescale 1ns/1ps
module sim_flag_alu;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opSel = '0;
  logic [31:0] dstIn = '0, srcIn = '0;
  logic [7:0]  shAmtIn = '0;
  logic [31:0] result;
  logic        wrEn, flagsValid;
  logic [5:0]  curFlags, flagsQ;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;  // 50 MHz

  flag_alu u0 (.*);

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [7:0]  cnt;
    logic [31:0] res;
    logic        wr;
    logic [5:0]  flg;  // {OF,SF,ZF,AF,PF,CF}
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 32'h7FFF_FFFF, 32'h0000_0001, 8'd0,  32'h8000_0000, 1'b1, 6'b110110}, // R1 R9 R7
    '{3'd0, 32'hFFFF_FFFF, 32'h0000_0001, 8'd0,  32'h0000_0000, 1'b1, 6'b001111}, // R1 R5 R8
    '{3'd1, 32'h0000_0000, 32'h0000_0001, 8'd0,  32'hFFFF_FFFF, 1'b1, 6'b010111}, // R1 R5 R6
    '{3'd1, 32'h8000_0000, 32'h0000_0001, 8'd0,  32'h7FFF_FFFF, 1'b1, 6'b100110}, // R1 R9
    '{3'd5, 32'h0000_0005, 32'h0000_0005, 8'd0,  32'h0000_0000, 1'b0, 6'b001010}, // R3
    '{3'd5, 32'h0000_0003, 32'h0000_0005, 8'd0,  32'hFFFF_FFFE, 1'b0, 6'b010101}, // R3 R5 R7
    '{3'd2, 32'hF0F0_00FF, 32'h0FF0_0F0F, 8'd0,  32'h00F0_000F, 1'b1, 6'b000010}, // R2
    '{3'd3, 32'h8000_0000, 32'h0000_0001, 8'd0,  32'h8000_0001, 1'b1, 6'b010000}, // R2 R6
    '{3'd4, 32'h1234_5678, 32'h1234_5678, 8'd0,  32'h0000_0000, 1'b1, 6'b001010}, // R2 R8
    '{3'd6, 32'hFFFF_FF00, 32'h8000_0F00, 8'd0,  32'h8000_0F00, 1'b0, 6'b010010}, // R3 R6
    '{3'd7, 32'h8000_0001, 32'h0,         8'd1,  32'h0000_0002, 1'b1, 6'b100001}, // R10
    '{3'd7, 32'h0000_00F0, 32'h0,         8'd4,  32'h0000_0F00, 1'b1, 6'b100010}, // R10 OF kept
    '{3'd7, 32'h4000_0000, 32'h0,         8'h21, 32'h8000_0000, 1'b1, 6'b110010}, // R4 mask
    '{3'd7, 32'h0000_0001, 32'h0,         8'd31, 32'h8000_0000, 1'b1, 6'b110010}  // R4 R10
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drives at a falling edge; checks comb outputs, then registered ones a cycle on
  task automatic runOp(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [7:0] cnt, input logic [31:0] expRes,
                       input logic expWr, input logic [5:0] expFlg, input string tag);
    opValid = 1'b1; opSel = op; dstIn = a; srcIn = b; shAmtIn = cnt;
    #2;
    check(result == expRes, {tag, " result"}, result, expRes);
    check(wrEn == expWr, {tag, " wrEn"}, 32'(wrEn), 32'(expWr));
    @(negedge clk);
    check(flagsQ == expFlg, {tag, " flags R5 R6 R7 R8 R9 R10"}, 32'(flagsQ), 32'(expFlg));
    check(flagsValid == 1'b1, "R12 flagsValid", 32'(flagsValid), 32'd1);
  endtask

  initial begin : watchdog
    #2000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R12 reset state
    check(flagsQ == 6'd0, "R12 reset flags", 32'(flagsQ), 32'd0);
    check(flagsValid == 1'b0, "R12 reset strobe", 32'(flagsValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      runOp(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].cnt, VECS[i].res,
            VECS[i].wr, VECS[i].flg, $sformatf("R1-vec%0d", i));
    end

    // R7: nibble carry without full carry
    runOp(3'd0, 32'h0000_000F, 32'h1, 8'd0, 32'h0000_0010, 1'b1, 6'b000100, "R7 nibble");

    // R11: masked count 0 (count 32) keeps flags, result equals dstIn
    runOp(3'd7, 32'hDEAD_BEEF, 32'h0, 8'd32, 32'hDEAD_BEEF, 1'b1, 6'b000100, "R11 shift0");

    // R12: idle cycle -> no strobe, flags held, no write
    opValid = 1'b0; opSel = 3'd0; dstIn = 32'hFFFF_FFFF; srcIn = 32'h1;
    #2;
    check(wrEn == 1'b0, "R1 wrEn idle", 32'(wrEn), 32'd0);
    @(negedge clk);
    check(flagsValid == 1'b0, "R12 idle strobe", 32'(flagsValid), 32'd0);
    check(flagsQ == 6'b000100, "R12 idle hold", 32'(flagsQ), 32'b000100);

    // R6: upper bits ignored by parity
    runOp(3'd2, 32'hFFFF_FF03, 32'h0000_FFFF, 8'd0, 32'h0000_FF03, 1'b1, 6'b000010, "R6 low byte");

    // R12: reset clears again
    rstN = 1'b0; opValid = 1'b0;
    #2;
    check(flagsQ == 6'd0, "R12 reset again", 32'(flagsQ), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule